// File: doc/BRIEF.md
# Fifty-Percent-Duty Programmable Clock Divider

This block derives a slower clock from a fast input clock. A 3-bit ratio code selects one of eight division factors, among them the odd factors 3 and 5. The output keeps an exact 50% duty cycle for every factor. For the odd factors the high phase ends on a falling input edge, so the output is high for a whole number of cycles plus one half cycle.

A true output and a complementary output are produced, together with a drive-enable flag and a valid flag. When the output is disabled, the pair is parked and the drive-enable flag goes low. A downstream pad or buffer turns that flag into high impedance.

The ratio code and the enable are sampled only at the start of an output period. Retuning or gating the divider therefore never truncates a pulse. An asynchronous active-high reset clears the counting state and parks the outputs. After reset is released, the divider starts from the ratio code present at its input.

Top module: `ratio_clk_divider`

## Requirements
- R1: Ratio codes 001, 010, 011, 100, 101, 110 and 111 divide the input clock by 2, 3, 4, 5, 6, 8 and 16, so one output period lasts N input cycles.
- R2: The output is high for exactly N half input cycles and low for exactly N half input cycles at every ratio, including the odd ratios 3 and 5.
- R3: Code 000 passes the input clock through to the true output, gated only by the enable, with no counting.
- R4: While reset is high, the true output is low, the complementary output is high and the valid flag is low.
- R5: After reset is released, the output toggles again using the ratio code present on the ratio input. A code that was held across reset is still in force afterwards.
- R6: A change of the ratio code takes effect only at the start of the next output period. The period in progress completes with the old ratio.
- R7: With the enable input at 0 (sampled at a period start), the true output is parked low, the complementary output is parked high and the drive-enable flag is 0. With the enable input at 1, the pair is driven and the flag is 1.
- R8: The complementary output is at all times the exact inverse of the true output.
- R9: The valid flag rises at the first input rising edge after reset is released and stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_i | input | 1 | Asynchronous active-high master reset |
| oe_i | input | 1 | Output enable, 1 drives the pair |
| ratio_i | input | 3 | Ratio code (000=÷1 … 111=÷16) |
| clk_o | output | 1 | Divided clock, true polarity |
| clk_n_o | output | 1 | Divided clock, complementary polarity |
| drive_en_o | output | 1 | Drive enable for the output pair, 0 means high impedance |
| valid_o | output | 1 | Divider running with a loaded code |

## Verification
The hardest case to reach from the ports is a ratio change in the middle of a long output period. The stimulus has to land the new code while the output is high, partway through a ÷16 period. To do this, the bench waits for the output to sit low, arms its scoreboard, waits for the next rising output edge, and only then changes the code to ÷2. The scoreboard expects one full 16-half-cycle high phase and one 16-half-cycle low phase, followed by runs of 2. Because every phase length is measured in half input cycles, any runt pulse and any off-by-one-half error on the odd ratios shows up as a wrong run length.

// File: rtl/rcd_pkg.sv
`timescale 1ns/1ps
package rcd_pkg;

    localparam int CODE_W    = 3;
    localparam int MAX_RATIO = 16;
    localparam int CNT_W     = $clog2(MAX_RATIO);

    typedef enum logic [CODE_W-1:0] {
        RC_PASS  = 3'd0,
        RC_DIV2  = 3'd1,
        RC_DIV3  = 3'd2,
        RC_DIV4  = 3'd3,
        RC_DIV5  = 3'd4,
        RC_DIV6  = 3'd5,
        RC_DIV8  = 3'd6,
        RC_DIV16 = 3'd7
    } ratio_code_e;

    // Division factor for a code; the pass-through code counts as 1.
    function automatic logic [CNT_W:0] ratio_of(input logic [CODE_W-1:0] code);
        logic [CNT_W:0] n;
        case (ratio_code_e'(code))
            RC_PASS:  n = (CNT_W+1)'(1);
            RC_DIV2:  n = (CNT_W+1)'(2);
            RC_DIV3:  n = (CNT_W+1)'(3);
            RC_DIV4:  n = (CNT_W+1)'(4);
            RC_DIV5:  n = (CNT_W+1)'(5);
            RC_DIV6:  n = (CNT_W+1)'(6);
            RC_DIV8:  n = (CNT_W+1)'(8);
            default:  n = (CNT_W+1)'(16);
        endcase
        return n;
    endfunction

    function automatic logic is_odd_code(input logic [CODE_W-1:0] code);
        return (code == RC_DIV3) || (code == RC_DIV5);
    endfunction

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [CODE_W-1:0] code;
        logic              en;
        logic              run;
        logic              pos;
    } phase_state_t;

    typedef struct packed {
        logic neg;
        logic en_n;
    } half_state_t;

endpackage

// File: rtl/rcd_phase_counter.sv
`timescale 1ns/1ps
module rcd_phase_counter
    import rcd_pkg::*;
#(
    parameter logic [CODE_W-1:0] DEF_CODE = RC_DIV4
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              oe_i,
    output logic [CODE_W-1:0] code_o,
    output logic              en_o,
    output logic              run_o,
    output logic              pos_o
);

    phase_state_t st_d, st_q;
    logic [CNT_W:0] n_cur;
    logic [CNT_W:0] n_new;
    logic           period_end;

    always_comb begin
        st_d       = st_q;
        n_cur      = ratio_of(st_q.code);
        period_end = ({1'b0, st_q.cnt} == (n_cur - 1'b1));
        if (!st_q.run || period_end) begin
            // Period boundary: sample the new code and enable here only.
            st_d.cnt  = '0;
            st_d.code = code_i;
            st_d.en   = oe_i;
        end else begin
            st_d.cnt  = st_q.cnt + 1'b1;
        end
        st_d.run = 1'b1;
        n_new    = ratio_of(st_d.code);
        // Rising-edge phase: high for floor(N/2) cycles from the period start.
        st_d.pos = ({1'b0, st_d.cnt} < (n_new >> 1));
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            st_q.cnt  <= '0;
            st_q.code <= DEF_CODE;
            st_q.en   <= 1'b1;
            st_q.run  <= 1'b0;
            st_q.pos  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_o = st_q.code;
    assign en_o   = st_q.en;
    assign run_o  = st_q.run;
    assign pos_o  = st_q.pos;

    a_r6_code_held_mid_period: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.run && st_q.cnt != '0) |-> $stable(st_q.code));

    a_r7_enable_held_mid_period: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.run && st_q.cnt != '0) |-> $stable(st_q.en));

    a_r1_count_in_range: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.run |-> ({1'b0, st_q.cnt} < ratio_of(st_q.code)));

    a_r9_valid_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.run |=> st_q.run);

endmodule

// File: rtl/rcd_half_shift.sv
`timescale 1ns/1ps
module rcd_half_shift
    import rcd_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic pos_i,
    input  logic en_i,
    output logic neg_o,
    output logic en_n_o
);

    half_state_t hs_d, hs_q;

    always_comb begin
        hs_d      = hs_q;
        hs_d.neg  = pos_i;
        hs_d.en_n = en_i;
    end

    // Falling-edge copies: stretch odd high phases by half a cycle and
    // retime the pass-through gate into the low phase of the input clock.
    always_ff @(negedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            hs_q.neg  <= 1'b0;
            hs_q.en_n <= 1'b1;
        end else begin
            hs_q <= hs_d;
        end
    end

    assign neg_o  = hs_q.neg;
    assign en_n_o = hs_q.en_n;

endmodule

// File: rtl/rcd_out_stage.sv
`timescale 1ns/1ps
module rcd_out_stage
    import rcd_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              pos_i,
    input  logic              neg_i,
    input  logic              en_i,
    input  logic              en_n_i,
    output logic              clk_o,
    output logic              clk_n_o,
    output logic              drive_en_o
);

    logic bypass;
    logic odd;
    logic div_raw;
    logic core;
    logic drv;

    always_comb begin
        bypass  = (code_i == RC_PASS);
        odd     = is_odd_code(code_i);
        div_raw = pos_i | (odd & neg_i);
        drv     = bypass ? en_n_i : en_i;
        core    = bypass ? clk_i : div_raw;
        clk_o   = drv & core;
        clk_n_o = ~clk_o;
        drive_en_o = drv;
    end

    a_r3_pass_follows_clock: assert property (@(negedge clk_i) disable iff (rst_i)
        (code_i == RC_PASS && en_n_i) |-> clk_o);

    a_r7_parked_when_off: assert property (@(negedge clk_i) disable iff (rst_i)
        !drive_en_o |-> (!clk_o && clk_n_o));

endmodule

// File: rtl/ratio_clk_divider.sv
`timescale 1ns/1ps
module ratio_clk_divider
    import rcd_pkg::*;
#(
    parameter logic [CODE_W-1:0] DEF_CODE = RC_DIV4
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              oe_i,
    input  logic [CODE_W-1:0] ratio_i,
    output logic              clk_o,
    output logic              clk_n_o,
    output logic              drive_en_o,
    output logic              valid_o
);

    logic [CODE_W-1:0] code_q;
    logic              en_q;
    logic              run_q;
    logic              pos_q;
    logic              neg_q;
    logic              en_n_q;

    rcd_phase_counter #(
        .DEF_CODE (DEF_CODE)
    ) u_phase (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .code_i (ratio_i),
        .oe_i   (oe_i),
        .code_o (code_q),
        .en_o   (en_q),
        .run_o  (run_q),
        .pos_o  (pos_q)
    );

    rcd_half_shift u_half (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .pos_i  (pos_q),
        .en_i   (en_q),
        .neg_o  (neg_q),
        .en_n_o (en_n_q)
    );

    rcd_out_stage u_out (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .code_i     (code_q),
        .pos_i      (pos_q),
        .neg_i      (neg_q),
        .en_i       (en_q),
        .en_n_i     (en_n_q),
        .clk_o      (clk_o),
        .clk_n_o    (clk_n_o),
        .drive_en_o (drive_en_o)
    );

    assign valid_o = run_q;

endmodule

// File: tb/ratio_clk_divider_tb.sv
`timescale 1ns/1ps
module ratio_clk_divider_tb;

    logic       clk = 1'b0;
    logic       rst_i = 1'b1;
    logic       oe_i = 1'b1;
    logic [2:0] ratio_i = 3'b011;
    logic       clk_o, clk_n_o, drive_en_o, valid_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    int    exp_q[$];
    string tag_q[$];
    bit    mon_on  = 0;
    bit    started = 0;
    int    run_len = 0;
    int    comp_bad = 0;
    logic  prev = 1'b0;

    always #2.5 clk = ~clk;

    ratio_clk_divider u_dut (
        .clk_i      (clk),
        .rst_i      (rst_i),
        .oe_i       (oe_i),
        .ratio_i    (ratio_i),
        .clk_o      (clk_o),
        .clk_n_o    (clk_n_o),
        .drive_en_o (drive_en_o),
        .valid_o    (valid_o)
    );

    function automatic int ratio_n(input logic [2:0] c);
        case (c)
            3'b000: return 1;
            3'b001: return 2;
            3'b010: return 3;
            3'b011: return 4;
            3'b100: return 5;
            3'b101: return 6;
            3'b110: return 8;
            default: return 16;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: measures output phase lengths in half input cycles.
    initial begin
        forever begin
            @(clk);
            #1.25;
            if (mon_on) begin
                if (clk_n_o !== ~clk_o) comp_bad++;
                if (!started) begin
                    if (prev === 1'b0 && clk_o === 1'b1) begin
                        started = 1;
                        run_len = 1;
                    end
                end else if (clk_o === prev) begin
                    run_len++;
                end else begin
                    if (exp_q.size() != 0) begin
                        int    e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check(run_len == e, t, run_len, e);
                    end
                    run_len = 1;
                end
            end
            prev = clk_o;
        end
    end

    task automatic push_runs(input int n, input int count, input string tag);
        for (int i = 0; i < count; i++) begin
            exp_q.push_back(n);
            tag_q.push_back(tag);
        end
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(posedge clk);
        #1.25;
        mon_on = 0;
        check(comp_bad == 0, "R8", comp_bad, 0);
    endtask

    // Driver: apply a code, let it reach a period start, expect six phases.
    task automatic run_code(input logic [2:0] code, input string tag);
        mon_on  = 0;
        ratio_i = code;
        repeat (40) @(posedge clk);
        #1.25;
        started  = 0;
        comp_bad = 0;
        push_runs(ratio_n(code), 6, tag);
        mon_on = 1;
        drain();
    endtask

    task automatic check_parked(input string tag);
        int bad = 0;
        for (int i = 0; i < 40; i++) begin
            @(clk);
            #1.25;
            if (clk_o !== 1'b0 || clk_n_o !== 1'b1 || drive_en_o !== 1'b0) bad++;
        end
        check(bad == 0, tag, bad, 0);
    endtask

    initial begin
        #1.25;
        // R4: reset state
        check(clk_o === 1'b0, "R4", clk_o, 0);
        check(clk_n_o === 1'b1, "R4", clk_n_o, 1);
        check(valid_o === 1'b0, "R4", valid_o, 0);
        repeat (3) @(negedge clk);
        #1.25;
        rst_i = 0;
        repeat (2) @(posedge clk);
        #1.25;
        check(valid_o === 1'b1, "R9", valid_o, 1);

        // R5: default code held across reset is in force
        run_code(3'b011, "R5");
        // R1, R2: every dividing code
        run_code(3'b001, "R1");
        run_code(3'b010, "R2");
        run_code(3'b100, "R2");
        run_code(3'b101, "R1");
        run_code(3'b110, "R1");
        run_code(3'b111, "R1");
        // R3: pass-through
        run_code(3'b000, "R3");

        // R6: change mid-period of a /16
        mon_on  = 0;
        ratio_i = 3'b111;
        repeat (40) @(posedge clk);
        #1.25;
        while (clk_o !== 1'b0) begin @(clk); #1.25; end
        started  = 0;
        comp_bad = 0;
        push_runs(16, 2, "R6");
        push_runs(2, 4, "R6");
        mon_on = 1;
        while (clk_o !== 1'b1) begin @(clk); #1.25; end
        repeat (3) @(posedge clk);
        #1.25;
        ratio_i = 3'b001;
        drain();

        // R7: disable with a dividing code, then re-enable
        ratio_i = 3'b011;
        repeat (20) @(posedge clk);
        #1.25;
        oe_i = 0;
        repeat (10) @(posedge clk);
        check_parked("R7");
        oe_i = 1;
        run_code(3'b011, "R7");
        // R7: disable in pass-through
        ratio_i = 3'b000;
        repeat (5) @(posedge clk);
        #1.25;
        oe_i = 0;
        repeat (4) @(posedge clk);
        check_parked("R7");
        oe_i = 1;
        run_code(3'b000, "R3");

        // R4/R5: reset in the middle of a /5 run, code held across it
        run_code(3'b100, "R1");
        repeat (7) @(posedge clk);
        #1.25;
        rst_i = 1;
        #0.5;
        check(clk_o === 1'b0, "R4", clk_o, 0);
        check(clk_n_o === 1'b1, "R4", clk_n_o, 1);
        check(valid_o === 1'b0, "R4", valid_o, 0);
        repeat (4) @(posedge clk);
        #1.25;
        check(clk_o === 1'b0 && valid_o === 1'b0, "R4", clk_o, 0);
        rst_i = 0;
        repeat (2) @(posedge clk);
        #1.25;
        check(valid_o === 1'b1, "R9", valid_o, 1);
        run_code(3'b100, "R5");

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule